// File: doc/BRIEF.md
# UART Interrupt Identification with End-of-Data Detection

This block is the interrupt logic of a 16550-style UART whose receive path feeds a DMA engine. It takes status from the serial datapath: the receive FIFO fill level, per-character error pulses, a 16x baud tick, the transmit-holding-empty level and modem-status change pulses. It keeps one pending flag per interrupt cause and drives a single interrupt line. It also presents a 3-bit code for the most urgent enabled cause. Software reaches it through a small register bus with an enable register, an identification register and a line status register.

Besides the classic causes, the block watches for a pause in the incoming stream. Once four character times pass with no new byte, it raises an end-of-data cause that tells a DMA driver a burst has finished. If that pause leaves a FIFO residue that is not a multiple of the 4-byte DMA word, it also raises a receive timeout, which is ranked above end-of-data. Software drains the residue by reading the FIFO and then handles end-of-data. In DMA mode the receive-at-trigger cause is suppressed, because end-of-data takes its place.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0x00, no cause is pending, irq is low, the identification register reads 0x01 and the line status register reads 0x00 (with FIFO empty and transmitter not empty).
- R2: The register map is address 0 = enable (read/write), 1 = identification (read), 2 = line status (read). The identification register reads {4'b0000, code[2:0], nopend}: nopend is 1 and the code is 0 when nothing is pending. irq is high exactly when an enabled cause is pending.
- R3: The cause codes are line error = 3, receive timeout = 6, end of data = 4, receive data = 2, transmit empty = 1 and modem change = 0. When several enabled causes are pending, they are ranked in that order, highest first.
- R4: The enable bits are bit 0 receive data, bit 1 transmit empty, bit 2 line error, bit 3 modem change, bit 4 receive timeout and bit 5 end of data. A disabled cause never drives irq or the code. Bits 7:6 are not stored and read as 0.
- R5: The receive-data cause is active while rx_level >= RX_TRIG (default 4) and dma_mode is 0. It is never reported while dma_mode is 1.
- R6: The line status register holds bit 0 data ready (rx_level != 0), bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break, bit 5 transmitter empty and bit 7 FIFO error. Bit 7 is set by a parity, framing or break error. Bits 1 to 4 and bit 7 are sticky and are cleared by reading the register. Any of bits 1 to 4 makes the line error cause pending. A break with no data ready reads as 0x90.
- R7: A gap is detected 4 x 160 = 640 baud ticks after the last received byte. Each rx_push restarts the count, and a gap fires once per pause.
- R8: A gap sets the end-of-data cause. It stays pending until its enable bit is written 0 and then 1. Rewriting the enable as 1 while it is already 1 does not clear it.
- R9: A gap that leaves rx_level with nonzero low two bits also sets the receive timeout, and a FIFO read (rx_pop) clears it. A gap that leaves a multiple of 4 raises end-of-data only.
- R10: The transmit-empty cause is set when thr_empty rises, or when its enable bit is written from 0 to 1 while thr_empty is high. It is cleared by reading the identification register while code 1 is shown, or by thr_empty going low.
- R11: A modem_change pulse sets the modem cause. Reading the identification register while code 0 is shown with nopend = 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_push | input | 1 | Pulse: a byte entered the receive FIFO |
| rx_pop | input | 1 | Pulse: a byte was read from the receive FIFO |
| err_overrun | input | 1 | Pulse: overrun error |
| err_parity | input | 1 | Pulse: parity error |
| err_frame | input | 1 | Pulse: framing error |
| err_break | input | 1 | Pulse: break detected |
| baud_tick | input | 1 | 16x baud tick enable |
| thr_empty | input | 1 | Transmit holding register empty |
| modem_change | input | 1 | Pulse: modem status changed |
| dma_mode | input | 1 | 1 selects DMA receive (end-of-data replaces receive data) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from addr) |
| irq | output | 1 | Interrupt request |
| int_id | output | 3 | Code of the highest pending enabled cause |

## Verification
The embedded properties check these rules on every cycle:
- a pending end-of-data survives every write that is not a 0-to-1 enable transition;
- an enabled line error always wins the code;
- a FIFO read always removes the timeout;
- transmit-empty drops the cycle after the holding register fills;
- reading the status register empties the sticky error bits;
- the gap detector fires once per pause.

The exact 640-tick distance, the restart of the count on a new byte, and the timeout-before-end-of-data ordering after a misaligned pause can only be shown by the bench scenarios. The same holds for the read-to-clear behaviour of the identification register and the exact bit patterns of the line status register.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_CAUSE = 6;

    typedef enum logic [2:0] {
        CAUSE_MODEM = 3'd0,
        CAUSE_THRE  = 3'd1,
        CAUSE_RDA   = 3'd2,
        CAUSE_LINE  = 3'd3,
        CAUSE_EOD   = 3'd4,
        CAUSE_RXTO  = 3'd6
    } cause_e;

    // enable register bit positions
    localparam int EN_RDA   = 0;
    localparam int EN_THRE  = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
    localparam int EN_RXTO  = 4;
    localparam int EN_EOD   = 5;
    localparam int EN_W     = 6;

    localparam logic [1:0] ADDR_IER = 2'd0;
    localparam logic [1:0] ADDR_IIR = 2'd1;
    localparam logic [1:0] ADDR_LSR = 2'd2;

    // rank 0 is the most urgent
    function automatic cause_e rank_code(input int rank);
        case (rank)
            0:       return CAUSE_LINE;
            1:       return CAUSE_RXTO;
            2:       return CAUSE_EOD;
            3:       return CAUSE_RDA;
            4:       return CAUSE_THRE;
            default: return CAUSE_MODEM;
        endcase
    endfunction

    typedef struct packed {
        logic [EN_W-1:0] ier;
        logic            thre;
        logic            thr_prev;
        logic            ms;
        logic            eod;
        logic            rxto;
    } ctl_t;

endpackage

// File: rtl/uart_irq_gap.sv
module uart_irq_gap #(
    parameter int CHAR_TICKS = 160,
    parameter int GAP_CHARS  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic rx_push,
    output logic gap_o
);
    localparam int GAP_TICKS = CHAR_TICKS * GAP_CHARS;
    localparam int CNT_W     = $clog2(GAP_TICKS + 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic             gap;
    } gap_t;

    gap_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.gap = 1'b0;
        if (rx_push) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (st_q.armed && baud_tick) begin
            if (st_q.cnt == CNT_W'(GAP_TICKS - 1)) begin
                st_d.gap   = 1'b1;
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gap_o = st_q.gap;

    AST_GAP_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.gap |=> !st_q.gap);                                   // R7
    AST_GAP_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gap && !rx_push) |=> !st_q.armed);                   // R7

endmodule

// File: rtl/uart_irq_line.sv
module uart_irq_line (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_overrun,
    input  logic       err_parity,
    input  logic       err_frame,
    input  logic       err_break,
    input  logic       lsr_rd,
    output logic [3:0] err_o,
    output logic       fifo_err_o
);
    typedef struct packed {
        logic [3:0] err;   // {break, frame, parity, overrun}
        logic       ferr;
    } line_t;

    line_t st_d, st_q;
    logic [3:0] new_err;

    always_comb begin
        new_err = {err_break, err_frame, err_parity, err_overrun};
        st_d    = st_q;
        if (lsr_rd) st_d = '0;
        st_d.err  = st_d.err | new_err;
        st_d.ferr = st_d.ferr | err_parity | err_frame | err_break;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o      = st_q.err;
    assign fifo_err_o = st_q.ferr;

    AST_LSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && new_err == 4'b0) |=> (st_q.err == 4'b0 && !st_q.ferr)); // R6

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NUM_CAUSE-1:0] pend_i,
    output cause_e               code_o,
    output logic                 any_o
);
    always_comb begin
        code_o = CAUSE_MODEM;
        for (int r = NUM_CAUSE - 1; r >= 0; r--) begin
            if (pend_i[r]) code_o = rank_code(r);
        end
        any_o = |pend_i;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int LVL_W      = 6,
    parameter int RX_TRIG    = 4,
    parameter int DMA_ALIGN  = 4,
    parameter int CHAR_TICKS = 160,
    parameter int GAP_CHARS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             err_overrun,
    input  logic             err_parity,
    input  logic             err_frame,
    input  logic             err_break,
    input  logic             baud_tick,
    input  logic             thr_empty,
    input  logic             modem_change,
    input  logic             dma_mode,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             irq,
    output logic [2:0]       int_id
);
    localparam int AL_W = $clog2(DMA_ALIGN);

    ctl_t st_d, st_q;

    logic                 gap;
    logic [3:0]           line_err;
    logic                 fifo_err;
    logic [NUM_CAUSE-1:0] pend;
    cause_e               code;
    logic                 any;
    logic                 ier_wr, iir_rd, lsr_rd;
    logic [EN_W-1:0]      ier_rise;
    logic [7:0]           iir_val, lsr_val;

    assign ier_wr = wr_en && (addr == ADDR_IER);
    assign iir_rd = rd_en && (addr == ADDR_IIR);
    assign lsr_rd = rd_en && (addr == ADDR_LSR);

    uart_irq_gap #(.CHAR_TICKS(CHAR_TICKS), .GAP_CHARS(GAP_CHARS)) u_gap (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .rx_push(rx_push), .gap_o(gap)
    );

    uart_irq_line u_line (
        .clk(clk), .rst_n(rst_n),
        .err_overrun(err_overrun), .err_parity(err_parity),
        .err_frame(err_frame), .err_break(err_break),
        .lsr_rd(lsr_rd), .err_o(line_err), .fifo_err_o(fifo_err)
    );

    // pending vector in rank order, rank 0 most urgent
    always_comb begin
        pend[0] = (|line_err) && st_q.ier[EN_LINE];
        pend[1] = st_q.rxto   && st_q.ier[EN_RXTO];
        pend[2] = st_q.eod    && st_q.ier[EN_EOD];
        pend[3] = (rx_level >= LVL_W'(RX_TRIG)) && !dma_mode && st_q.ier[EN_RDA];
        pend[4] = st_q.thre   && st_q.ier[EN_THRE];
        pend[5] = st_q.ms     && st_q.ier[EN_MODEM];
    end

    uart_irq_prio u_prio (.pend_i(pend), .code_o(code), .any_o(any));

    always_comb begin
        st_d          = st_q;
        st_d.thr_prev = thr_empty;
        ier_rise      = '0;
        if (ier_wr) begin
            st_d.ier = wdata[EN_W-1:0];
            ier_rise = wdata[EN_W-1:0] & ~st_q.ier;
        end
        // transmit empty
        if (iir_rd && any && code == CAUSE_THRE) st_d.thre = 1'b0;
        if (thr_empty && (!st_q.thr_prev || ier_rise[EN_THRE])) st_d.thre = 1'b1;
        if (!thr_empty) st_d.thre = 1'b0;
        // modem change
        if (iir_rd && any && code == CAUSE_MODEM) st_d.ms = 1'b0;
        if (modem_change) st_d.ms = 1'b1;
        // end of data: cleared only by an enable 0->1 transition
        if (ier_rise[EN_EOD]) st_d.eod = 1'b0;
        if (gap) st_d.eod = 1'b1;
        // receive timeout on misaligned residue
        if (rx_pop || rx_push) st_d.rxto = 1'b0;
        if (gap && rx_level[AL_W-1:0] != '0) st_d.rxto = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        iir_val = {4'b0000, code, ~any};
        lsr_val = {fifo_err, 1'b0, thr_empty, line_err, (rx_level != '0)};
        case (addr)
            ADDR_IER: rdata = {{(8 - EN_W){1'b0}}, st_q.ier};
            ADDR_IIR: rdata = iir_val;
            ADDR_LSR: rdata = lsr_val;
            default:  rdata = 8'h00;
        endcase
    end

    assign irq    = any;
    assign int_id = code;

    AST_EOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.eod && !(ier_wr && wdata[EN_EOD] && !st_q.ier[EN_EOD])) |=> st_q.eod); // R8
    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((|line_err) && st_q.ier[EN_LINE]) |-> (int_id == 3'd3 && irq));             // R3
    AST_RXTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !gap) |=> !st_q.rxto);                                             // R9
    AST_THRE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_empty |=> !st_q.thre);                                                   // R10
    AST_RDA_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && !(|line_err) && !st_q.rxto && !st_q.eod) |-> int_id != 3'd2);   // R5

endmodule

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] rx_level;
    logic       rx_push, rx_pop;
    logic       err_overrun, err_parity, err_frame, err_break;
    logic       baud_tick, thr_empty, modem_change, dma_mode;
    logic       wr_en, rd_en;
    logic [1:0] addr;
    logic [7:0] wdata, rdata;
    logic       irq;
    logic [2:0] int_id;

    int tests = 0;
    int fails = 0;
    logic [7:0] got;

    always #2 clk = ~clk;

    uart_irq_ident u0 (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_push(rx_push),
        .rx_pop(rx_pop), .err_overrun(err_overrun), .err_parity(err_parity),
        .err_frame(err_frame), .err_break(err_break), .baud_tick(baud_tick),
        .thr_empty(thr_empty), .modem_change(modem_change), .dma_mode(dma_mode),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .int_id(int_id)
    );

    // {ier[7:0], lvl[5:0], events{modem,break,frame,parity,overrun}, thr, dma, exp_iir[7:0]}
    localparam int NVEC = 12;
    localparam logic [28:0] VEC [NVEC] = '{
        {8'h00, 6'd5, 5'b11111, 1'b1, 1'b0, 8'h01}, // R4 all disabled
        {8'h01, 6'd5, 5'b00000, 1'b0, 1'b0, 8'h04}, // R5 level above trigger
        {8'h01, 6'd3, 5'b00000, 1'b0, 1'b0, 8'h01}, // R5 level below trigger
        {8'h01, 6'd5, 5'b00000, 1'b0, 1'b1, 8'h01}, // R5 dma suppresses
        {8'h02, 6'd0, 5'b00000, 1'b1, 1'b0, 8'h02}, // R10 transmit empty
        {8'h05, 6'd5, 5'b00001, 1'b0, 1'b0, 8'h06}, // R3 line over receive data
        {8'h07, 6'd5, 5'b00000, 1'b1, 1'b0, 8'h04}, // R3 receive data over transmit
        {8'h04, 6'd0, 5'b01000, 1'b0, 1'b0, 8'h06}, // R6 break is line error
        {8'h08, 6'd0, 5'b10000, 1'b0, 1'b0, 8'h00}, // R11 modem code 0
        {8'h0A, 6'd0, 5'b10000, 1'b1, 1'b0, 8'h02}, // R3 transmit over modem
        {8'h3F, 6'd7, 5'b00110, 1'b1, 1'b1, 8'h06}, // R3 all enabled
        {8'h0B, 6'd0, 5'b10000, 1'b1, 1'b0, 8'h02}  // R4 receive data idle
    };

    task automatic chk(input string tag, input logic [7:0] g, input logic [7:0] e);
        tests++;
        if (g !== e) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, g, e);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_level = '0; rx_push = 0; rx_pop = 0;
        err_overrun = 0; err_parity = 0; err_frame = 0; err_break = 0;
        baud_tick = 0; thr_empty = 0; modem_change = 0; dma_mode = 0;
        wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_ier(input logic [7:0] v);
        wr_en = 1'b1; addr = 2'd0; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic push(input logic [5:0] lvl);
        rx_level = lvl; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic ticks(input int n);
        baud_tick = 1'b1;
        repeat (n) @(negedge clk);
        baud_tick = 1'b0;
    endtask

    task automatic pulse_ev(input logic [4:0] ev);
        {modem_change, err_break, err_frame, err_parity, err_overrun} = ev;
        @(negedge clk);
        {modem_change, err_break, err_frame, err_parity, err_overrun} = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        // table walk
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            rx_level  = VEC[i][20:15];
            thr_empty = VEC[i][9];
            dma_mode  = VEC[i][8];
            wr_ier(VEC[i][28:21]);
            pulse_ev(VEC[i][14:10]);
            @(negedge clk);
            chk($sformatf("R2 vector %0d irq", i), {7'b0, irq}, {7'b0, ~VEC[i][0]});
            rd(2'd1, got);
            chk($sformatf("R3 vector %0d iir", i), got, VEC[i][7:0]);
        end

        // R1 reset state
        do_reset();
        chk("R1 irq", {7'b0, irq}, 8'h00);
        rd(2'd1, got); chk("R1 iir", got, 8'h01);
        rd(2'd0, got); chk("R1 ier", got, 8'h00);
        rd(2'd2, got); chk("R1 lsr", got, 8'h00);

        // R4 enable readback, upper bits not stored
        wr_ier(8'hFF);
        rd(2'd0, got); chk("R4 ier readback", got, 8'h3F);

        // R6 line status patterns
        do_reset();
        pulse_ev(5'b01000);
        rd(2'd2, got); chk("R6 break no data", got, 8'h90);
        rd(2'd2, got); chk("R6 cleared by read", got, 8'h00);
        pulse_ev(5'b00001);
        rd(2'd2, got); chk("R6 overrun", got, 8'h02);
        pulse_ev(5'b00100);
        rd(2'd2, got); chk("R6 framing", got, 8'h88);
        rx_level = 6'd2; thr_empty = 1'b1;
        @(negedge clk);
        rd(2'd2, got); chk("R6 ready and empty", got, 8'h21);

        // R10 transmit empty clearing and re-arming
        do_reset();
        thr_empty = 1'b1;
        wr_ier(8'h02);
        rd(2'd1, got); chk("R10 shown", got, 8'h02);
        rd(2'd1, got); chk("R10 cleared by iir read", got, 8'h01);
        thr_empty = 1'b0; repeat (2) @(negedge clk);
        thr_empty = 1'b1; repeat (2) @(negedge clk);
        rd(2'd1, got); chk("R10 rising edge", got, 8'h02);

        // R11 modem clear
        do_reset();
        wr_ier(8'h08);
        pulse_ev(5'b10000);
        rd(2'd1, got); chk("R11 shown", got, 8'h00);
        rd(2'd1, got); chk("R11 cleared", got, 8'h01);

        // R5 dma switch at run time
        do_reset();
        rx_level = 6'd6;
        wr_ier(8'h01);
        rd(2'd1, got); chk("R5 pio", got, 8'h04);
        dma_mode = 1'b1; @(negedge clk);
        rd(2'd1, got); chk("R5 dma", got, 8'h01);

        // R7 R8 R9 misaligned pause
        do_reset();
        dma_mode = 1'b1;
        wr_ier(8'h30);
        push(6'd3);
        ticks(600);
        rd(2'd1, got); chk("R7 before gap", got, 8'h01);
        ticks(100);
        rd(2'd1, got); chk("R9 timeout first", got, 8'h0C);
        rx_level = 6'd0; rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        @(negedge clk);
        rd(2'd1, got); chk("R9 then end of data", got, 8'h08);
        wr_ier(8'h30);
        rd(2'd1, got); chk("R8 rewrite keeps", got, 8'h08);
        wr_ier(8'h10);
        rd(2'd1, got); chk("R8 masked", got, 8'h01);
        wr_ier(8'h30);
        rd(2'd1, got); chk("R8 toggled clear", got, 8'h01);

        // R9 aligned residue
        do_reset();
        wr_ier(8'h30);
        push(6'd4);
        ticks(700);
        rd(2'd1, got); chk("R9 aligned eod only", got, 8'h08);

        // R7 count restarts on each byte
        do_reset();
        wr_ier(8'h20);
        push(6'd1);
        ticks(500);
        push(6'd2);
        ticks(500);
        rd(2'd1, got); chk("R7 restart no gap", got, 8'h01);
        ticks(200);
        rd(2'd1, got); chk("R7 gap after restart", got, 8'h08);

        // R3 line error beats timeout
        do_reset();
        wr_ier(8'h34);
        push(6'd1);
        ticks(700);
        pulse_ev(5'b00010);
        rd(2'd1, got); chk("R3 line over timeout", got, 8'h06);
        rd(2'd2, got); chk("R6 parity with data", got, 8'h85);
        rd(2'd1, got); chk("R3 timeout next", got, 8'h0C);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule